// File: doc/BRIEF.md
# Byte-wide expansion ROM read bridge

This block is a memory-read target on a simplified parallel-bus interface. Behind it sits an 8-bit external ROM, and it returns 32-bit words from that ROM. A base register places a 1 MB window in the 32-bit address space. The block claims a memory read in that window only when the memory-space enable and the ROM enable bit of the base register are both set. It then drives the ROM with the word offset of the access inside the window. It reads four consecutive bytes, stepping only the two low address bits, and holds chip-select and output-enable asserted for a programmable number of clocks per byte.

The four bytes are packed little-endian into one word. The block signals target-ready when the last byte has been captured. If the initiator announced a burst, the block also raises stop in that same data phase, so exactly one word is returned for each transaction. The read-multiple and read-line command codes behave as a plain memory read. Writes and I/O cycles are never claimed. The ROM write strobe stays inactive at all times.

Top module: `xrom_read_bridge`

## Requirements
- R1: While reset is asserted and after it is released with no request, tgt_claim, tgt_ready and tgt_stop are 0, and rom_cs_n, rom_oe_n and rom_we_n are 1.
- R2: A request is claimed only if cfg_mem_en is 1 and bit 0 of cfg_rom_bar is 1. If either is 0, tgt_claim stays 0 and rom_cs_n stays 1.
- R3: With both enables set, a memory read is claimed exactly when req_addr minus {cfg_rom_bar[31:20], 20'h0} is below 2^20. The last word base+0xFFFFC is claimed, while base+0x100000 and base-4 are not.
- R4: During a claimed read, rom_addr equals bits 19:0 of (req_addr minus the base) with bits 1:0 replaced by the byte index. The index is 0, 1, 2 and 3 in turn, and bus address bits 1:0 are ignored.
- R5: Each byte lasts N clocks, where N is cfg_access_clks and a value of 0 means 1. rom_cs_n and rom_oe_n are both 0 for all 4N clocks and rise when target-ready appears. tgt_ready is 1 in the cycle after the 4N-th clock edge that follows the edge sampling req_start.
- R6: tgt_ready is a single-cycle pulse. Together with it, tgt_rdata holds the byte from index 0 in bits 7:0, index 1 in 15:8, index 2 in 23:16 and index 3 in 31:24, each sampled on the last clock of its count.
- R7: tgt_stop is 1 together with tgt_ready when req_burst was 1 at the request, and 0 otherwise. It is never 1 without tgt_ready.
- R8: Command codes 4'b1100 and 4'b1110 are claimed and served exactly like the memory read code 4'b0110.
- R9: Write codes (such as 4'b0111) and I/O codes (4'b0010, 4'b0011) are not claimed even inside the window, and rom_we_n is always 1.
- R10: A req_start that arrives while a read is in progress is ignored. The running read returns its own data, and no second read follows.
- R11: tgt_claim rises in the cycle after the edge that samples a hitting req_start and stays 1 up to and including the tgt_ready cycle. It falls in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mem_en | input | 1 | Memory-space enable |
| cfg_rom_bar | input | 32 | ROM base register: bits 31:20 base, bit 0 ROM enable |
| cfg_access_clks | input | 4 | Clocks per ROM byte (0 means 1) |
| req_start | input | 1 | Address-phase strobe, one cycle |
| req_addr | input | 32 | Bus address of the request |
| req_cmd | input | 4 | Bus command code |
| req_burst | input | 1 | Initiator intends more than one data phase |
| tgt_claim | output | 1 | Target has claimed the transaction |
| tgt_ready | output | 1 | Read data valid, one cycle |
| tgt_stop | output | 1 | Disconnect request, with tgt_ready |
| tgt_rdata | output | 32 | Assembled read word |
| rom_addr | output | 20 | Byte address to the ROM |
| rom_data | input | 8 | Data from the ROM |
| rom_cs_n | output | 1 | ROM chip-select, active low |
| rom_oe_n | output | 1 | ROM output-enable, active low |
| rom_we_n | output | 1 | ROM write strobe, held inactive |

## Verification
Reads are issued at the bottom of the window, at its last word and at a misaligned address. These show the offset subtraction and the ignored low bits. Addresses one word past each edge, and reads with one enable cleared, separate the window test from the enable gating. Per-byte counts of 0, 1, 2, 3, 9 and 15 are used. They distinguish an off-by-one in the count from a fault in the byte stepping, and the ROM model's data depends on the address, so a byte sampled from the wrong index or lane shows up as a wrong word. The read-multiple and read-line codes, write and I/O codes, burst against single phase, and a second request during a running read separate command aliasing, claim gating, disconnect and busy handling.

// File: rtl/xrb_pkg.sv
package xrb_pkg;

   localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
   localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
   localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_DONE  = 2'd2
   } xrb_state_e;

   function automatic logic xrb_is_mem_read(input logic [3:0] cmd);
      return (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_RD_MULT) ||
             (cmd == CMD_MEM_RD_LINE);
   endfunction

endpackage

// File: rtl/xrb_decode.sv
module xrb_decode
   import xrb_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int WIN_BITS = 20
) (
   input  logic                cfg_mem_en,
   input  logic [ADDR_W-1:0]   cfg_bar,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [3:0]          cmd,
   output logic                hit,
   output logic [WIN_BITS-1:0] offset
);

   localparam int TAG_W = ADDR_W - WIN_BITS;

   generate
      if (WIN_BITS < 2 || TAG_W < 1) begin : g_bad_window
         $error("xrb_decode: window must leave room for a base tag");
      end
   endgenerate

   logic [ADDR_W-1:0] base_full;
   logic [ADDR_W-1:0] diff;
   logic              in_window;
   logic              enabled;
   logic              unused_bar_bits;

   assign base_full       = {cfg_bar[ADDR_W-1:WIN_BITS], {WIN_BITS{1'b0}}};
   assign diff            = addr - base_full;
   assign in_window       = (diff[ADDR_W-1:WIN_BITS] == '0);
   assign enabled         = cfg_mem_en & cfg_bar[0];
   assign hit             = enabled & in_window & xrb_is_mem_read(cmd);
   assign offset          = diff[WIN_BITS-1:0];
   assign unused_bar_bits = ^cfg_bar[WIN_BITS-1:1];

endmodule

// File: rtl/xrb_seq.sv
module xrb_seq
   import xrb_pkg::*;
#(
   parameter int CNT_W = 4,
   parameter int LANES = 4,
   parameter int OFF_W = 18,
   localparam int LANE_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  access_clks,
   input  logic [OFF_W-1:0]  word_off,
   input  logic              burst,
   output logic              busy,
   output logic              fetching,
   output logic              done,
   output logic              stop,
   output logic              capture,
   output logic [LANE_W-1:0] lane,
   output logic [OFF_W-1:0]  off_q
);

   localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

   generate
      if (LANES < 2 || (1 << LANE_W) != LANES) begin : g_bad_lanes
         $error("xrb_seq: lane count must be a power of two of at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("xrb_seq: count width must be at least 1");
      end
   endgenerate

   xrb_state_e        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  lim_q;
   logic [CNT_W-1:0]  lim_d;
   logic [LANE_W-1:0] lane_q;
   logic              burst_q;
   logic              last_clk;

   assign lim_d    = (access_clks == '0) ? '0 : access_clks - 1'b1;
   assign last_clk = (cnt_q == lim_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         lim_q   <= '0;
         lane_q  <= '0;
         off_q   <= '0;
         burst_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_FETCH;
                  cnt_q   <= '0;
                  lim_q   <= lim_d;
                  lane_q  <= '0;
                  off_q   <= word_off;
                  burst_q <= burst;
               end
            end
            ST_FETCH: begin
               if (last_clk) begin
                  cnt_q <= '0;
                  if (lane_q == LAST_LANE) begin
                     state_q <= ST_DONE;
                  end else begin
                     lane_q <= lane_q + 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_DONE: begin
               state_q <= ST_IDLE;
               burst_q <= 1'b0;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign fetching = (state_q == ST_FETCH);
   assign done     = (state_q == ST_DONE);
   assign stop     = done & burst_q;
   assign capture  = fetching & last_clk;
   assign lane     = lane_q;

endmodule

// File: rtl/xrb_pack.sv
module xrb_pack #(
   parameter int LANES  = 4,
   parameter int BYTE_W = 8,
   parameter bit LITTLE = 1'b1,
   localparam int LANE_W = $clog2(LANES),
   localparam int WORD_W = LANES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [LANE_W-1:0] lane,
   input  logic [BYTE_W-1:0] din,
   output logic [WORD_W-1:0] word
);

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic [BYTE_W-1:0] byte_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               byte_q <= '0;
            end else if (capture && (lane == LANE_W'(i))) begin
               byte_q <= din;
            end
         end

         if (LITTLE) begin : g_le
            assign word[i*BYTE_W +: BYTE_W] = byte_q;
         end else begin : g_be
            assign word[(LANES-1-i)*BYTE_W +: BYTE_W] = byte_q;
         end
      end
   endgenerate

endmodule

// File: rtl/xrom_read_bridge.sv
module xrom_read_bridge
   import xrb_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int WIN_BITS  = 20,
   parameter int ROM_DW    = 8,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 4,
   parameter bit LITTLE_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_mem_en,
   input  logic [ADDR_W-1:0]   cfg_rom_bar,
   input  logic [CNT_W-1:0]    cfg_access_clks,
   input  logic                req_start,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [3:0]          req_cmd,
   input  logic                req_burst,
   output logic                tgt_claim,
   output logic                tgt_ready,
   output logic                tgt_stop,
   output logic [DATA_W-1:0]   tgt_rdata,
   output logic [WIN_BITS-1:0] rom_addr,
   input  logic [ROM_DW-1:0]   rom_data,
   output logic                rom_cs_n,
   output logic                rom_oe_n,
   output logic                rom_we_n
);

   localparam int LANES  = DATA_W / ROM_DW;
   localparam int LANE_W = $clog2(LANES);
   localparam int OFF_W  = WIN_BITS - LANE_W;

   generate
      if (DATA_W % ROM_DW != 0) begin : g_bad_ratio
         $error("xrom_read_bridge: bus width must be a multiple of ROM width");
      end
      if (OFF_W < 1) begin : g_bad_off
         $error("xrom_read_bridge: window too small for the lane count");
      end
   endgenerate

   logic                hit;
   logic [WIN_BITS-1:0] offset;
   logic                busy;
   logic                fetching;
   logic                done;
   logic                stop;
   logic                capture;
   logic [LANE_W-1:0]   lane;
   logic [OFF_W-1:0]    off_q;
   logic                unused_offset_low;

   xrb_decode #(
      .ADDR_W   (ADDR_W),
      .WIN_BITS (WIN_BITS)
   ) i_decode (
      .cfg_mem_en (cfg_mem_en),
      .cfg_bar    (cfg_rom_bar),
      .addr       (req_addr),
      .cmd        (req_cmd),
      .hit        (hit),
      .offset     (offset)
   );

   xrb_seq #(
      .CNT_W (CNT_W),
      .LANES (LANES),
      .OFF_W (OFF_W)
   ) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (req_start & hit),
      .access_clks (cfg_access_clks),
      .word_off    (offset[WIN_BITS-1:LANE_W]),
      .burst       (req_burst),
      .busy        (busy),
      .fetching    (fetching),
      .done        (done),
      .stop        (stop),
      .capture     (capture),
      .lane        (lane),
      .off_q       (off_q)
   );

   xrb_pack #(
      .LANES  (LANES),
      .BYTE_W (ROM_DW),
      .LITTLE (LITTLE_EN)
   ) i_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .lane    (lane),
      .din     (rom_data),
      .word    (tgt_rdata)
   );

   assign unused_offset_low = ^offset[LANE_W-1:0];

   assign tgt_claim = busy;
   assign tgt_ready = done;
   assign tgt_stop  = stop;
   assign rom_addr  = {off_q, lane};
   assign rom_cs_n  = ~fetching;
   assign rom_oe_n  = ~fetching;
   assign rom_we_n  = 1'b1;

endmodule

// File: rtl/xrb_checker.sv
module xrb_checker #(
   parameter int WIN_BITS = 20,
   parameter int LANE_W   = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_start,
   input logic                tgt_claim,
   input logic                tgt_ready,
   input logic                tgt_stop,
   input logic [WIN_BITS-1:0] rom_addr,
   input logic                rom_cs_n,
   input logic                rom_oe_n,
   input logic                rom_we_n
);

   assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_ready |=> !tgt_ready);

   assert_stop_with_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_stop |-> tgt_ready);

   assert_ready_claimed_R11: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_ready |-> tgt_claim);

   assert_claim_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tgt_claim) |-> $past(req_start));

   assert_strobes_paired_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rom_cs_n) |-> (!rom_oe_n && tgt_claim && !tgt_ready));

   assert_word_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rom_cs_n && $past(!rom_cs_n)) |-> $stable(rom_addr[WIN_BITS-1:LANE_W]));

   assert_lane_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rom_cs_n && $past(!rom_cs_n) && !$stable(rom_addr[LANE_W-1:0])) |->
      (rom_addr[LANE_W-1:0] == $past(rom_addr[LANE_W-1:0]) + 1'b1));

   assert_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rom_we_n);

endmodule

bind xrom_read_bridge xrb_checker #(
   .WIN_BITS (WIN_BITS),
   .LANE_W   (LANE_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_start (req_start),
   .tgt_claim (tgt_claim),
   .tgt_ready (tgt_ready),
   .tgt_stop  (tgt_stop),
   .rom_addr  (rom_addr),
   .rom_cs_n  (rom_cs_n),
   .rom_oe_n  (rom_oe_n),
   .rom_we_n  (rom_we_n)
);

// File: tb/test_xrom_read_bridge.sv
`timescale 1ns/1ps
module test_xrom_read_bridge;

   typedef struct packed {
      logic        mem_en;
      logic        rom_en;
      logic [11:0] base;
      logic [31:0] addr;
      logic [3:0]  cmd;
      logic        burst;
      logic [3:0]  wt;
      logic        claim;
   } vec_t;

   localparam int NVEC = 12;
   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 1'b1, 12'hC01, 32'hC010_0000, 4'b0110, 1'b0, 4'd9,  1'b1}, // R3 bottom, default count
      '{1'b1, 1'b1, 12'hC01, 32'hC01F_FFFC, 4'b0110, 1'b0, 4'd2,  1'b1}, // R3 last word
      '{1'b1, 1'b1, 12'hC01, 32'hC020_0000, 4'b0110, 1'b0, 4'd2,  1'b0}, // R3 one past top
      '{1'b1, 1'b1, 12'hC01, 32'hC00F_FFFC, 4'b0110, 1'b0, 4'd2,  1'b0}, // R3 below base
      '{1'b0, 1'b1, 12'hC01, 32'hC010_0040, 4'b0110, 1'b0, 4'd2,  1'b0}, // R2 memory disabled
      '{1'b1, 1'b0, 12'hC01, 32'hC010_0040, 4'b0110, 1'b0, 4'd2,  1'b0}, // R2 ROM disabled
      '{1'b1, 1'b1, 12'hC01, 32'hC012_3456, 4'b1100, 1'b1, 4'd3,  1'b1}, // R8 R7 R4 misaligned
      '{1'b1, 1'b1, 12'hC01, 32'hC010_0100, 4'b1110, 1'b0, 4'd1,  1'b1}, // R8
      '{1'b1, 1'b1, 12'hC01, 32'hC010_0010, 4'b0111, 1'b0, 4'd2,  1'b0}, // R9 write
      '{1'b1, 1'b1, 12'hC01, 32'hC010_0010, 4'b0010, 1'b0, 4'd2,  1'b0}, // R9 I/O
      '{1'b1, 1'b1, 12'hC01, 32'hC01A_BCD8, 4'b0110, 1'b1, 4'd0,  1'b1}, // R5 zero count
      '{1'b1, 1'b1, 12'h7FF, 32'h7FF0_FFF0, 4'b0110, 1'b0, 4'd15, 1'b1}  // R5 max count
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_mem_en = 1'b0;
   logic [31:0] cfg_rom_bar = '0;
   logic [3:0]  cfg_access_clks = 4'd9;
   logic        req_start = 1'b0;
   logic [31:0] req_addr = '0;
   logic [3:0]  req_cmd = '0;
   logic        req_burst = 1'b0;
   logic        tgt_claim, tgt_ready, tgt_stop;
   logic [31:0] tgt_rdata;
   logic [19:0] rom_addr;
   logic [7:0]  rom_data;
   logic        rom_cs_n, rom_oe_n, rom_we_n;

   int n_cmp = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   function automatic logic [7:0] rom_f(input logic [19:0] a);
      return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h3C;
   endfunction

   assign rom_data = rom_f(rom_addr);

   xrom_read_bridge i_xrom_read_bridge (
      .clk             (clk),
      .rst_n           (rst_n),
      .cfg_mem_en      (cfg_mem_en),
      .cfg_rom_bar     (cfg_rom_bar),
      .cfg_access_clks (cfg_access_clks),
      .req_start       (req_start),
      .req_addr        (req_addr),
      .req_cmd         (req_cmd),
      .req_burst       (req_burst),
      .tgt_claim       (tgt_claim),
      .tgt_ready       (tgt_ready),
      .tgt_stop        (tgt_stop),
      .tgt_rdata       (tgt_rdata),
      .rom_addr        (rom_addr),
      .rom_data        (rom_data),
      .rom_cs_n        (rom_cs_n),
      .rom_oe_n        (rom_oe_n),
      .rom_we_n        (rom_we_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input logic [19:0] off);
      return {rom_f(off + 20'd3), rom_f(off + 20'd2), rom_f(off + 20'd1), rom_f(off)};
   endfunction

   task automatic issue(input vec_t v);
      @(negedge clk);
      cfg_mem_en      = v.mem_en;
      cfg_rom_bar     = {v.base, 19'h0, v.rom_en};
      cfg_access_clks = v.wt;
      req_addr        = v.addr;
      req_cmd         = v.cmd;
      req_burst       = v.burst;
      req_start       = 1'b1;
      @(negedge clk);
      req_start       = 1'b0;
   endtask

   task automatic run_vec(input vec_t v);
      int          n;
      int          cyc;
      bit          addr_ok, strobe_ok, claim_ok, idle_ok;
      logic [19:0] off;
      logic [31:0] diff;
      string       dtag;
      issue(v);
      if (v.claim) begin
         n    = (v.wt == 0) ? 1 : int'(v.wt);
         diff = v.addr - {v.base, 20'h0};
         off  = diff[19:0] & 20'hFFFFC;
         dtag = (v.cmd != 4'b0110) ? "R8 data" : "R6 data";
         cyc = 1; addr_ok = 1; strobe_ok = 1; claim_ok = 1;
         while (!tgt_ready && cyc < 400) begin
            if (rom_addr !== off + 20'((cyc - 1) / n)) addr_ok = 0;
            if (rom_cs_n !== 1'b0 || rom_oe_n !== 1'b0) strobe_ok = 0;
            if (tgt_claim !== 1'b1) claim_ok = 0;
            @(negedge clk);
            cyc++;
         end
         chk("R5 ready cycle", cyc, 4 * n + 1);
         chk("R4 rom address sequence", {31'h0, addr_ok}, 32'd1);
         chk("R5 strobes held", {31'h0, strobe_ok}, 32'd1);
         chk("R5 strobes released", {30'h0, rom_cs_n, rom_oe_n}, 32'd3);
         chk("R11 claim held", {31'h0, claim_ok & tgt_claim}, 32'd1);
         chk(dtag, tgt_rdata, exp_word(off));
         chk("R7 stop", {31'h0, tgt_stop}, {31'h0, v.burst});
         @(negedge clk);
         chk("R11 claim released", {31'h0, tgt_claim}, 32'd0);
         chk("R6 ready single", {31'h0, tgt_ready}, 32'd0);
      end else begin
         idle_ok = 1;
         for (int k = 0; k < 12; k++) begin
            if (tgt_claim !== 1'b0 || tgt_ready !== 1'b0 || rom_cs_n !== 1'b1 ||
                rom_we_n !== 1'b1) idle_ok = 0;
            @(negedge clk);
         end
         chk("R2 R3 R9 not claimed", {31'h0, idle_ok}, 32'd1);
      end
   endtask

   initial begin : main
      vec_t v;
      bit   quiet;
      repeat (3) @(negedge clk);
      // R1: during reset
      chk("R1 reset outputs", {28'h0, tgt_claim, tgt_ready, tgt_stop, rom_we_n}, 32'd1);
      chk("R1 reset strobes", {30'h0, rom_cs_n, rom_oe_n}, 32'd3);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 after release", {27'h0, tgt_claim, tgt_ready, tgt_stop, rom_cs_n, rom_oe_n}, 32'd3);

      for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

      // R10: request during a running read is ignored
      v = '{1'b1, 1'b1, 12'hC01, 32'hC010_0020, 4'b0110, 1'b0, 4'd3, 1'b1};
      issue(v);
      @(negedge clk);
      req_addr  = 32'hC010_0080;
      req_burst = 1'b1;
      req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      while (!tgt_ready) @(negedge clk);
      chk("R10 first data kept", tgt_rdata, exp_word(20'h00020));
      chk("R10 no stop from second", {31'h0, tgt_stop}, 32'd0);
      quiet = 1;
      @(negedge clk);
      for (int k = 0; k < 20; k++) begin
         if (tgt_claim !== 1'b0 || rom_cs_n !== 1'b1) quiet = 0;
         @(negedge clk);
      end
      chk("R10 no second read", {31'h0, quiet}, 32'd1);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
         $finish;
      end
   end

endmodule